// File: doc/BRIEF.md
# Packed-Lane Shift-and-Insert Unit

This block merges a shifted 64-bit source vector into a 64-bit destination vector. The vector is split into equal lanes of 8, 16, 32 or 64 bits. In every lane the source is shifted left or right by the same amount. The destination bits that the shifted source does not reach are kept, not cleared. A vector datapath uses it to pack bit fields into existing data without a separate mask-and-OR sequence.

A single 7-bit immediate holds both the lane size and the shift amount, and a direction input selects left or right insertion. An immediate too small to name any lane size is flagged as an error, and in that case the destination is passed through unchanged. The result is registered, and a valid strobe follows the input strobe one cycle later.

Top module: `simd_shins`

## Requirements
- R1: The lane size is the largest power of two that is not above `imm_code`. It is 64 when bit 6 is set, otherwise 32 when bit 5 is set, otherwise 16 when bit 4 is set, otherwise 8 when bit 3 is set. The vector holds 64/size lanes.
- R2: With `dir_right`=0 (left insert), the shift is `imm_code` minus the lane size, in the range 0 to size-1. Each result lane is the source lane shifted left, with the low shift bits taken from the destination lane.
- R3: With `dir_right`=1 (right insert), the shift is twice the lane size minus `imm_code`, in the range 1 to size. Each result lane is the source lane shifted right logically, with the top shift bits taken from the destination lane.
- R4: No bit crosses a lane boundary. Shifted-out source bits are dropped, and the kept destination bits come only from the same lane.
- R5: A right insert whose shift equals the lane size (`imm_code` equal to 8, 16, 32 or 64) returns the destination lane unchanged.
- R6: An `imm_code` below 8 sets `out_err`=1 and returns `dst_vec` unchanged. Any valid code clears `out_err`.
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_vec` and `out_err` load only in a cycle with `in_valid`=1 and hold in every other cycle.
- R8: While reset is asserted, and for two clocks after `rst_n` rises, `out_valid`, `out_err` and `out_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and control are valid this cycle |
| src_vec | input | 64 | Vector that is shifted |
| dst_vec | input | 64 | Vector whose uncovered bits are kept |
| imm_code | input | 7 | Combined lane-size and shift immediate |
| dir_right | input | 1 | 1 selects right insert, 0 selects left insert |
| out_valid | output | 1 | Registered result is new this cycle |
| out_vec | output | 64 | Registered merged vector |
| out_err | output | 1 | The last accepted immediate was below 8 |

## Verification
The assertions assume that the operands, the immediate and the direction are known whenever `in_valid` is high. They also assume that these inputs settle well before the clock edge that captures them. The bench drives every input on the falling edge and returns `in_valid` low between bursts, which keeps it inside these assumptions. The stimulus covers immediates across the whole 7-bit range, both below and above 8, with both directions, and uses random gaps so that hold cycles occur between results.

// File: rtl/shins_pkg.sv
package shins_pkg;
  localparam int VEC_W     = 64;
  localparam int IMM_W     = 7;
  localparam int MIN_LANE  = 8;
  localparam int LOG_MIN   = $clog2(MIN_LANE);
  localparam int NUM_SIZES = $clog2(VEC_W / MIN_LANE) + 1;
  localparam int SH_W      = IMM_W + 1;
endpackage

// File: rtl/shins_rst_sync.sv
module shins_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/shins_decode.sv
module shins_decode
  import shins_pkg::*;
(
  input  logic [IMM_W-1:0]     imm,
  input  logic                 right,
  output logic                 err,
  output logic [NUM_SIZES-1:0] size_oh,
  output logic [SH_W-1:0]      shift
);
  logic [SH_W-1:0] lane_sz;
  logic            found;

  always_comb begin
    size_oh = '0;
    found   = 1'b0;
    lane_sz = '0;
    for (int k = NUM_SIZES - 1; k >= 0; k--) begin
      if (!found && imm[LOG_MIN + k]) begin
        size_oh[k] = 1'b1;
        found      = 1'b1;
        lane_sz    = SH_W'(MIN_LANE << k);
      end
    end
    err = !found;
    if (!found)
      shift = '0;
    else if (right)
      shift = (lane_sz << 1) - {1'b0, imm};
    else
      shift = {1'b0, imm} - lane_sz;
  end

  // R2 R3
  always_comb begin
    if (!err) begin
      shift_range_chk: assert (right ? (shift >= SH_W'(1) && shift <= lane_sz)
                                     : (shift < lane_sz))
        else $error("shift out of range for lane size");
    end
  end

  // R1
  always_comb begin
    size_sel_chk: assert ($onehot0(size_oh) && (err == (size_oh == '0)))
      else $error("lane size select not one-hot");
  end
endmodule

// File: rtl/shins_lane.sv
module shins_lane #(
  parameter int LANE_W = 8,
  parameter int SH_W   = 8
) (
  input  logic [LANE_W-1:0] src,
  input  logic [LANE_W-1:0] dst,
  input  logic [SH_W-1:0]   shift,
  input  logic              right,
  output logic [LANE_W-1:0] res
);
  logic [LANE_W-1:0] keep;
  logic [LANE_W-1:0] moved;

  always_comb begin
    if (right) begin
      keep  = ~({LANE_W{1'b1}} >> shift);
      moved = src >> shift;
    end else begin
      keep  = ~({LANE_W{1'b1}} << shift);
      moved = src << shift;
    end
    res = moved | (dst & keep);
  end

  // R5
  always_comb begin
    if (right && shift == SH_W'(LANE_W)) begin
      full_keep_chk: assert (res == dst)
        else $error("full-width right insert altered destination");
    end
  end
endmodule

// File: rtl/simd_shins.sv
module simd_shins
  import shins_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [IMM_W-1:0] imm_code,
  input  logic             dir_right,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_err
);
  logic                 rst_q_n;
  logic                 dec_err;
  logic [NUM_SIZES-1:0] dec_size_oh;
  logic [SH_W-1:0]      dec_shift;
  logic [VEC_W-1:0]     res_by_size [NUM_SIZES];
  logic [VEC_W-1:0]     merged;
  logic [VEC_W-1:0]     vec_d;
  logic                 err_d;
  logic                 valid_d;

  shins_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  shins_decode u_dec (
    .imm     (imm_code),
    .right   (dir_right),
    .err     (dec_err),
    .size_oh (dec_size_oh),
    .shift   (dec_shift)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW = MIN_LANE << g;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      shins_lane #(.LANE_W(LW), .SH_W(SH_W)) u_lane (
        .src   (src_vec[l*LW +: LW]),
        .dst   (dst_vec[l*LW +: LW]),
        .shift (dec_shift),
        .right (dir_right),
        .res   (res_by_size[g][l*LW +: LW])
      );
    end
  end

  always_comb begin
    merged = dst_vec;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (dec_size_oh[g]) merged = res_by_size[g];
    end
  end

  always_comb begin
    valid_d = in_valid;
    vec_d   = in_valid ? merged  : out_vec;
    err_d   = in_valid ? dec_err : out_err;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_vec   <= vec_d;
      out_err   <= err_d;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid)
    else $error("out_valid missing after accepted input");

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_err)))
    else $error("output changed without input valid");

  // R6
  bad_imm_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && imm_code < IMM_W'(MIN_LANE)) |=> (out_err && out_vec == $past(dst_vec)))
    else $error("invalid immediate not passed through");

  // R1
  good_imm_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && imm_code >= IMM_W'(MIN_LANE)) |=> !out_err)
    else $error("error flag on a valid immediate");
endmodule

// File: tb/tb_simd_shins.sv
`timescale 1ns/100ps
module tb_simd_shins;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_vec = '0;
  logic [63:0] dst_vec = '0;
  logic [6:0]  imm_code = '0;
  logic        dir_right = 1'b0;
  logic        out_valid;
  logic [63:0] out_vec;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit live = 0;

  typedef struct {
    logic [63:0] v;
    bit          e;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  simd_shins dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .dst_vec(dst_vec), .imm_code(imm_code),
    .dir_right(dir_right), .out_valid(out_valid),
    .out_vec(out_vec), .out_err(out_err)
  );

  function automatic void ref_model(input logic [63:0] s, input logic [63:0] d,
                                    input logic [6:0] imm, input bit right,
                                    output logic [63:0] r, output bit e);
    int w;
    int sh;
    if (imm >= 64) w = 64;
    else if (imm >= 32) w = 32;
    else if (imm >= 16) w = 16;
    else if (imm >= 8) w = 8;
    else w = 0;
    if (w == 0) begin
      r = d;
      e = 1'b1;
      return;
    end
    e  = 1'b0;
    sh = right ? (2 * w - int'(imm)) : (int'(imm) - w);
    for (int i = 0; i < 64; i++) begin
      int b;
      b = i % w;
      if (!right) r[i] = (b >= sh) ? s[i - sh] : d[i];
      else        r[i] = (b < w - sh) ? s[i + sh] : d[i];
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] s, input logic [63:0] d,
                      input logic [6:0] imm, input bit right, input string tag);
    exp_t it;
    @(negedge clk);
    src_vec = s; dst_vec = d; imm_code = imm; dir_right = right; in_valid = 1'b1;
    ref_model(s, d, imm, right, it.v, it.e);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_vec  = 64'hDEAD_BEEF_0BAD_F00D ^ {32'(i), 32'(i)};
      imm_code = 7'(i);
    end
  endtask

  // monitor / scoreboard
  logic [63:0] last_vec;
  bit          last_err;
  initial begin
    last_vec = '0;
    last_err = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (live && !finished) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", out_vec, '0);
          end else begin
            exp_t it;
            it = exp_q.pop_front();
            check(out_vec == it.v, it.tag, out_vec, it.v);
            check(out_err == it.e, {it.tag, " err flag R6"},
                  {63'b0, out_err}, {63'b0, it.e});
          end
          last_vec = out_vec;
          last_err = out_err;
        end else begin
          check(out_vec == last_vec && out_err == last_err,
                "R7 hold while idle", out_vec, last_vec);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    #(5 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R8: reset state
    #12;
    check(out_valid == 1'b0 && out_err == 1'b0, "R8 flags in reset",
          {62'b0, out_valid, out_err}, '0);
    check(out_vec == '0, "R8 vector in reset", out_vec, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vec == '0 && out_valid == 1'b0, "R8 held during sync release",
          out_vec, '0);
    idle(3);
    live = 1;

    // R2: shift 0 in 8-bit lanes returns source
    send(64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd8, 1'b0, "R2 left sh0 w8");
    // R2: shift 7 keeps low 7 bits of each destination lane
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 7'd15, 1'b0, "R2 left sh7 w8");
    // R1: 16-bit lanes, shift 4
    send(64'h1234_5678_9ABC_DEF0, 64'h000F_000F_000F_000F, 7'd20, 1'b0, "R1 left w16 sh4");
    // R3: right shift 7 in 8-bit lanes
    send(64'h8080_8080_8080_8080, 64'h0000_0000_0000_0000, 7'd9, 1'b1, "R3 right w8 sh7");
    idle(2);
    // R5: right shift equal to lane size keeps destination
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_1234_8765, 7'd8, 1'b1, "R5 right w8 full");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_1234_8765, 7'd32, 1'b1, "R5 right w32 full");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'hC3C3_3C3C_0F0F_F0F0, 7'd64, 1'b1, "R5 right w64 full");
    // R4: all-ones source must not leak across 32-bit lanes
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 7'd40, 1'b0, "R4 left w32 sh8");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 7'd56, 1'b1, "R4 right w32 sh8");
    // R3: 64-bit lane, shift 1
    send(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 7'd127, 1'b1, "R3 right w64 sh1");
    // R2: 64-bit lane, shift 63
    send(64'h0000_0000_0000_0003, 64'h1111_2222_3333_4444, 7'd127, 1'b0, "R2 left w64 sh63");
    // R6: invalid immediates, then recovery
    send(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd5, 1'b0, "R6 bad imm 5");
    send(64'h0123_4567_89AB_CDEF, 64'h0F0F_0F0F_0F0F_0F0F, 7'd0, 1'b1, "R6 bad imm 0");
    send(64'h0123_4567_89AB_CDEF, 64'h0F0F_0F0F_0F0F_0F0F, 7'd7, 1'b1, "R6 bad imm 7");
    send(64'h0123_4567_89AB_CDEF, 64'h0F0F_0F0F_0F0F_0F0F, 7'd17, 1'b1, "R6 clear after bad");
    idle(4);

    // R7: random operands with random gaps
    for (int n = 0; n < 400; n++) begin
      logic [63:0] s;
      logic [63:0] d;
      s = {$urandom, $urandom};
      d = {$urandom, $urandom};
      send(s, d, 7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)),
           "R7 random stream R1 R2 R3");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(4);
    check(exp_q.size() == 0, "R7 all results delivered",
          64'(exp_q.size()), '0);
    finish_run();
  end
endmodule